// File: doc/BRIEF.md
# Display Clock Gating and Pixel Divider

This block supplies the clocks that a display controller needs. It makes three gated copies of the main system clock: one for the bus interface, one for the register port and one for the video-RAM arbiter. It also makes one pixel clock, which is the oscillator clock divided by a programmable ratio from 1 to 16. A plain register port sets the three enable bits and the 4-bit divider select. The port has an address, a write strobe, write data and combinational read data.

Each gated clock uses an enable latch that is transparent while the main clock is low. An enable change therefore shows up only on a whole clock pulse. The divider select crosses into the oscillator domain through a synchronizer. The new value is applied only when the pixel period in progress ends. This means the output never shows a shortened pulse while the ratio changes.

Top module: `dispclk_ctrl`

## Requirements
- R1: Each gated clock produces one rising edge per system clock cycle while its enable bit is 1. It produces no edge while the bit is 0. An enable change never produces a shortened pulse.
- R2: The bus-interface clock enable is bit 2 of offset 0x00. The register-port clock enable is bit 1 of the same offset. Both are 0 after reset.
- R3: The video-RAM arbiter clock enable is bit 19 of offset 0x04. It is 1 after reset.
- R4: The divider select is bits [19:16] of offset 0x08, and the divide ratio is select+1. The select is 7 after reset, which gives divide-by-8.
- R5: The pixel clock period is ratio oscillator cycles. For ratio 2 and above, the high phase lasts floor(ratio/2) oscillator cycles. For ratio 1 the oscillator clock passes straight through.
- R6: A new select takes effect only at the end of the pixel period in progress. That period keeps its old length, and the next period uses the new ratio.
- R7: Bits that are not implemented read as 0 and ignore writes. A write to any offset other than 0x00, 0x04 or 0x08 changes nothing, and such an offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Main system clock, the source of the gated clocks |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| osc_clk | input | 1 | Oscillator clock, the source of the pixel clock |
| osc_rst_n | input | 1 | Synchronous active-low reset, oscillator domain |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled on sys_clk |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| bus_gclk | output | 1 | Gated bus-interface clock |
| regs_gclk | output | 1 | Gated register-port clock |
| arb_gclk | output | 1 | Gated video-RAM arbiter clock |
| pix_clk | output | 1 | Divided pixel clock |

## Verification
The bench steps the divider select through all sixteen values. At each value it measures the full period and the high time of the pixel clock in oscillator cycles. This separates the straight-through ratio from the even ratios, which split evenly, and from the odd ratios, which give the spare cycle to the low phase. A ratio change written in the middle of a long period shows whether that period keeps its old length or is cut short. For each gated clock, the bench counts edges in a fixed window with the enable off, then on, then off again. Writes of all ones and writes to unmapped offsets show whether any unimplemented bit or address can be changed.

// File: rtl/dispclk_pkg.sv
// Package: shared register layout and reset values for the display clock unit.
// Assumes a byte-addressed register port with word-aligned offsets.
package dispclk_pkg;
    localparam int SEL_W        = 4;
    localparam int OFS_GATE0    = 'h00;
    localparam int OFS_GATE1    = 'h04;
    localparam int OFS_DIV      = 'h08;
    localparam int BIT_BUS      = 2;
    localparam int BIT_REGS     = 1;
    localparam int BIT_ARB      = 19;
    localparam int BIT_SEL_LO   = 16;
    localparam logic [SEL_W-1:0] SEL_RST = 4'd7;
    localparam int N_GATES      = 3;
    localparam int G_BUS        = 0;
    localparam int G_REGS       = 1;
    localparam int G_ARB        = 2;
endpackage

// File: rtl/dispclk_regs.sv
// Module: register file holding the clock enables and the divider select.
// Assumes writes take effect on the sys_clk edge with reg_we high; reads are combinational.
module dispclk_regs
    import dispclk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_GATES-1:0] gate_en,
    output logic [SEL_W-1:0]  div_sel
);
    timeunit 1ns; timeprecision 1ps;

    logic en_bus_q, en_regs_q, en_arb_q;
    logic [SEL_W-1:0] sel_q;
    logic hit_g0, hit_g1, hit_div;

    // Decode the three mapped offsets.
    always_comb begin
        hit_g0  = (addr == ADDR_W'(OFS_GATE0));
        hit_g1  = (addr == ADDR_W'(OFS_GATE1));
        hit_div = (addr == ADDR_W'(OFS_DIV));
    end

    // Store written fields; only implemented bits are captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bus_q  <= 1'b0;
            en_regs_q <= 1'b0;
            en_arb_q  <= 1'b1;
            sel_q     <= SEL_RST;
        end else if (we) begin
            if (hit_g0) begin
                en_bus_q  <= wdata[BIT_BUS];
                en_regs_q <= wdata[BIT_REGS];
            end
            if (hit_g1)  en_arb_q <= wdata[BIT_ARB];
            if (hit_div) sel_q    <= wdata[BIT_SEL_LO +: SEL_W];
        end
    end

    // Assemble read data with unimplemented bits at zero.
    always_comb begin
        rdata = '0;
        if (hit_g0) begin
            rdata[BIT_BUS]  = en_bus_q;
            rdata[BIT_REGS] = en_regs_q;
        end
        if (hit_g1)  rdata[BIT_ARB] = en_arb_q;
        if (hit_div) rdata[BIT_SEL_LO +: SEL_W] = sel_q;
    end

    // Route fields to the gates and divider.
    always_comb begin
        gate_en[G_BUS]  = en_bus_q;
        gate_en[G_REGS] = en_regs_q;
        gate_en[G_ARB]  = en_arb_q;
        div_sel         = sel_q;
    end

    // R7: a write to an unmapped offset leaves all fields unchanged.
    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit_g0 && !hit_g1 && !hit_div) |=> ($stable(gate_en) && $stable(div_sel)));
    // R3: the arbiter enable takes the written bit 19.
    a_r3_arb_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_g1) |=> (gate_en[G_ARB] == $past(wdata[BIT_ARB])));
    // R4: the select takes written bits [19:16].
    a_r4_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_div) |=> (div_sel == $past(wdata[BIT_SEL_LO +: SEL_W])));
endmodule

// File: rtl/dispclk_gate.sv
// Module: glitch-free clock gate with an enable latch open while the clock is low.
// Assumes the enable is launched from flops on the rising edge of the same clock.
module dispclk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    timeunit 1ns; timeprecision 1ps;

    logic en_lat;

    // Capture the enable only during the low phase of the clock.
    always_latch begin
        if (!clk) en_lat = en;
    end

    // Pass whole high phases only.
    assign gclk = clk & en_lat;
endmodule

// File: rtl/dispclk_div.sv
// Module: divide the oscillator clock by select+1 (1..16) without runt pulses.
// Assumes the select is quasi-static and comes from another clock domain.
module dispclk_div
    import dispclk_pkg::*;
(
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_async,
    output logic             pix_clk
);
    timeunit 1ns; timeprecision 1ps;

    logic [SEL_W-1:0] sel_meta, sel_sync, sel_prev, sel_pend;
    logic [SEL_W-1:0] cur_last, cnt;
    logic [SEL_W-1:0] nxt_last, nxt_cnt;
    logic [SEL_W:0]   nxt_half;
    logic             period_end, div_q, bypass_q;

    // Bring the select into the oscillator domain; accept it only when two samples agree.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            sel_meta <= SEL_RST;
            sel_sync <= SEL_RST;
            sel_prev <= SEL_RST;
            sel_pend <= SEL_RST;
        end else begin
            sel_meta <= sel_async;
            sel_sync <= sel_meta;
            sel_prev <= sel_sync;
            if (sel_sync == sel_prev) sel_pend <= sel_prev;
        end
    end

    // Work out the next count, ratio and output level.
    always_comb begin
        period_end = (cnt == cur_last);
        nxt_last   = period_end ? sel_pend : cur_last;
        nxt_cnt    = period_end ? '0 : cnt + 1'b1;
        nxt_half   = ({1'b0, nxt_last} + 1'b1) >> 1;
    end

    // Advance the counter and load a new ratio only at a period boundary.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            cur_last <= SEL_RST;
            cnt      <= '0;
            div_q    <= 1'b1;
            bypass_q <= 1'b0;
        end else begin
            cur_last <= nxt_last;
            cnt      <= nxt_cnt;
            div_q    <= ({1'b0, nxt_cnt} < nxt_half);
            bypass_q <= (nxt_last == '0);
        end
    end

    // Ratio 1 passes the oscillator through.
    assign pix_clk = bypass_q ? osc_clk : div_q;

    // R5: the count never passes the last cycle of the period.
    a_r5_cnt_bound: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cnt <= cur_last);
    // R5: the divided output rises only at the start of a period.
    a_r5_rise_at_start: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(div_q) |-> (cnt == '0));
    // R6: the ratio holds until the period in progress ends.
    a_r6_ratio_at_end: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (cnt != cur_last) |=> $stable(cur_last));
endmodule

// File: rtl/dispclk_ctrl.sv
// Module: top of the display clock unit: register file, three clock gates, pixel divider.
// Assumes each reset is synchronous to its own clock.
module dispclk_ctrl
    import dispclk_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              osc_clk,
    input  logic              osc_rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_gclk,
    output logic              regs_gclk,
    output logic              arb_gclk,
    output logic              pix_clk
);
    timeunit 1ns; timeprecision 1ps;

    logic [N_GATES-1:0] gate_en;
    logic [N_GATES-1:0] gclk;
    logic [SEL_W-1:0]   div_sel;

    dispclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(sys_clk), .rst_n(sys_rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .gate_en(gate_en), .div_sel(div_sel)
    );

    // One gate per enabled copy of the system clock.
    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        dispclk_gate u_gate (.clk(sys_clk), .en(gate_en[g]), .gclk(gclk[g]));
    end

    assign bus_gclk  = gclk[G_BUS];
    assign regs_gclk = gclk[G_REGS];
    assign arb_gclk  = gclk[G_ARB];

    dispclk_div u_div (
        .osc_clk(osc_clk), .rst_n(osc_rst_n), .sel_async(div_sel), .pix_clk(pix_clk)
    );
endmodule

// File: tb/dispclk_ctrl_tb.sv
module dispclk_ctrl_tb;
    timeunit 1ns; timeprecision 1ps;

    localparam real SYS_T = 10.0;
    localparam real OSC_T = 14.0;

    logic        sys_clk = 0, osc_clk = 0, sys_rst_n = 0, osc_rst_n = 0;
    logic [7:0]  reg_addr = 0;
    logic        reg_we = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        bus_gclk, regs_gclk, arb_gclk, pix_clk;

    int n_chk = 0, n_fail = 0, mon_done = 0;
    int e_bus = 0, e_regs = 0, e_arb = 0;

    typedef struct { int ratio; string tag; } exp_t;
    exp_t exp_q[$];

    dispclk_ctrl u_dut (.*);

    always #(SYS_T/2) sys_clk = ~sys_clk;
    always #(OSC_T/2) osc_clk = ~osc_clk;

    always @(posedge bus_gclk)  e_bus++;
    always @(posedge regs_gclk) e_regs++;
    always @(posedge arb_gclk)  e_arb++;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge sys_clk); reg_addr = 8'(a); reg_wdata = d; reg_we = 1;
        @(negedge sys_clk); reg_we = 0;
    endtask

    task automatic rd_check(string req, int a, logic [31:0] exp);
        @(negedge sys_clk); reg_addr = 8'(a); #1;
        check(req, int'(reg_rdata), int'(exp));
    endtask

    // Count edges on each gated clock over 20 system cycles.
    task automatic gate_window(string req, int x_bus, int x_regs, int x_arb);
        repeat (2) @(negedge sys_clk);
        e_bus = 0; e_regs = 0; e_arb = 0;
        repeat (20) @(negedge sys_clk);
        check({req, " bus"},  e_bus,  x_bus);
        check({req, " regs"}, e_regs, x_regs);
        check({req, " arb"},  e_arb,  x_arb);
    endtask

    // Driver: program a select, let it settle, then queue the expected ratio.
    task automatic drive_sel(int sel, string tag);
        wr('h08, 32'(sel) << 16);
        #(OSC_T * 60);
        exp_q.push_back('{ratio: sel + 1, tag: tag});
        wait (exp_q.size() == 0);
        wait (mon_done > 0);
        mon_done = 0;
    endtask

    // Monitor: measure one pixel period and high time, compare with queue head.
    initial begin
        forever begin
            exp_t e;
            realtime t0, t1, t2;
            int exp_hi;
            wait (exp_q.size() > 0);
            e = exp_q[0];
            @(posedge pix_clk); t0 = $realtime;
            @(negedge pix_clk); t1 = $realtime;
            @(posedge pix_clk); t2 = $realtime;
            exp_hi = (e.ratio == 1) ? 1 : 2 * (e.ratio / 2);
            check({e.tag, " period"}, $rtoi((t2 - t0) / OSC_T + 0.5), e.ratio);
            check({e.tag, " high half-cycles"}, $rtoi((t1 - t0) * 2.0 / OSC_T + 0.5), exp_hi);
            void'(exp_q.pop_front());
            mon_done = 1;
        end
    end

    initial begin
        #(2ms);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        realtime ta, tb;
        repeat (4) @(negedge sys_clk);
        @(negedge osc_clk) osc_rst_n = 1;
        @(negedge sys_clk) sys_rst_n = 1;

        // Reset state: R2, R3, R4.
        rd_check("R2 reset offset 0x00", 'h00, 32'h0);
        rd_check("R3 reset offset 0x04", 'h04, 32'h0008_0000);
        rd_check("R4 reset offset 0x08", 'h08, 32'h0007_0000);
        exp_q.push_back('{ratio: 8, tag: "R4 reset divide-by-8"});
        wait (mon_done > 0); mon_done = 0;

        // Gated clocks at reset and after enable changes: R1, R2, R3.
        gate_window("R1 reset gates", 0, 0, 20);
        wr('h00, 32'h4);
        gate_window("R1 R2 bus only", 20, 0, 20);
        wr('h00, 32'h2);
        gate_window("R1 R2 regs only", 0, 20, 20);
        wr('h04, 32'h0);
        wr('h00, 32'h6);
        gate_window("R1 R3 arb off", 20, 20, 0);
        wr('h00, 32'h0);
        wr('h04, 32'h0008_0000);
        gate_window("R1 back to reset", 0, 0, 20);

        // Unimplemented bits and unmapped offsets: R7.
        wr('h00, 32'hFFFF_FFFF);
        rd_check("R7 offset 0x00 mask", 'h00, 32'h6);
        wr('h04, 32'hFFF7_FFFF);
        rd_check("R7 offset 0x04 mask", 'h04, 32'h0);
        wr('h08, 32'hFFFF_FFFF);
        rd_check("R7 offset 0x08 mask", 'h08, 32'h000F_0000);
        wr('h0C, 32'hFFFF_FFFF);
        wr('h01, 32'h0);
        rd_check("R7 unmapped reads 0", 'h0C, 32'h0);
        rd_check("R7 0x00 kept", 'h00, 32'h6);
        rd_check("R7 0x04 kept", 'h04, 32'h0);
        rd_check("R7 0x08 kept", 'h08, 32'h000F_0000);
        gate_window("R7 gates after unmapped", 20, 20, 0);
        wr('h00, 32'h0);
        wr('h04, 32'h0008_0000);

        // All select values: R4, R5.
        for (int s = 0; s < 16; s++) drive_sel(s, $sformatf("R4 R5 sel %0d", s));

        // Ratio change mid-period: R6.
        drive_sel(15, "R6 setup ratio 16");
        @(posedge pix_clk); ta = $realtime;
        #(OSC_T * 5);
        wr('h08, 32'h0002_0000);
        @(posedge pix_clk); tb = $realtime;
        check("R6 period in progress keeps ratio 16", $rtoi((tb - ta) / OSC_T + 0.5), 16);
        ta = tb;
        @(posedge pix_clk); tb = $realtime;
        check("R6 next period uses ratio 3", $rtoi((tb - ta) / OSC_T + 0.5), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule